// File: doc/BRIEF.md
# Windowed Trigger Matcher

This block stamps each incoming hit with the current bunch count and keeps it in a circular level-1 store. Each trigger is queued with its bunch count and event number. For each queued trigger the block finds the stored hits whose stamp falls inside a programmable window placed relative to the trigger. It then sends, on a valid/ready stream, a header word, one word per matched hit and a trailer word. Windows of nearby triggers may overlap, so one stored hit can appear in several events. A separate ageing rule removes hits from the store once they are too old to be useful, so the store does not fill up when triggers are rare.

With the pass-through control set, triggers are ignored and every stored hit is sent out once, oldest first, as a bare hit word. Serialization onto a physical link is done outside this block.

Top module: `trig_match`

## Requirements
- R1: The bunch counter (BC_W bits) counts up by one every clock and wraps. On `bc_clr` it loads `bc_preset` instead. A hit is stamped with the counter value of the cycle in which `hit_valid` is sampled.
- R2: An accepted trigger gets the counter value of its cycle and an event number. Event numbers start at 0 after reset and go up by one for each accepted trigger. The header word is kind 2'b10 in the top two bits, then the event number, then the trigger bunch count in the low BC_W bits.
- R3: A hit belongs to an event when (stamp − (trigger count − `win_offset`)) mod 2^BC_W < `win_width`. Processing of an event waits until the whole window lies in the past. A matched hit word is kind 2'b00 with {stamp, data} zero-extended in the payload, with the data in the low HIT_W bits.
- R4: A hit that lies inside the windows of several triggers is reported in every one of those events, in hit arrival order.
- R5: Outside event processing and outside pass-through, the oldest stored hit is removed when (current count − stamp) mod 2^BC_W > `reject_lim`. A removed hit no longer matches any later trigger.
- R6: A hit that arrives while the store holds L1_DEPTH hits is dropped. The next trailer then has its error bit, bit HCNT_W of the payload, set to 1, and the trailer after that has it at 0.
- R7: A trigger that arrives while the trigger queue is full is discarded, and the saturating counter `drop_cnt` goes up by one.
- R8: When `bypass` is 1, triggers have no effect (no event, no drop count). Stored hits are sent out in arrival order as hit words.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- R10: After reset, `out_valid` and `drop_cnt` are 0.
- R11: The trailer word is kind 2'b11. Its low HCNT_W bits give the number of hit words sent in that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 1 | A hit is present this cycle |
| hit_data | input | HIT_W | Hit payload (e.g. channel) |
| trig_in | input | 1 | Trigger pulse |
| bc_clr | input | 1 | Load bunch counter with preset |
| bc_preset | input | BC_W | Value loaded by bc_clr |
| win_offset | input | BC_W | Window start, counts before trigger |
| win_width | input | BC_W | Window length in counts |
| reject_lim | input | BC_W | Maximum kept hit age |
| bypass | input | 1 | Untriggered pass-through |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts word |
| out_data | output | BC_W+EVT_W+2 | Kind in top two bits, payload below |
| drop_cnt | output | DROP_W | Saturating count of discarded triggers |

## Verification
The hardest states to reach are a full trigger queue and a full hit store, because in normal running both drain by themselves. The bench holds `out_ready` low so that the first event stalls on its header, then fires a burst of triggers that fills the queue and spills over. For the store, it sets the ageing limit to its maximum and sends more hits than the store holds before any trigger, then uses two wide windows to see the error bit set and then cleared. Overlap is reached with triggers two cycles apart whose windows reach past the trigger, so the matcher also has to wait for later hits.

// File: rtl/tm_pkg.sv
package tm_pkg;
  typedef enum logic [1:0] {
    K_HIT = 2'b00,
    K_HDR = 2'b10,
    K_TRL = 2'b11
  } word_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_SCAN,
    ST_TRL
  } match_state_t;
endpackage

// File: rtl/tm_bunch_ctr.sv
module tm_bunch_ctr #(
  parameter int BC_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [BC_W-1:0] preset,
  output logic [BC_W-1:0] bc
);
  always_ff @(posedge clk) begin
    if (rst)      bc <= '0;
    else if (clr) bc <= preset;
    else          bc <= bc + 1'b1;
  end
endmodule

// File: rtl/tm_hit_buf.sv
module tm_hit_buf #(
  parameter int DEPTH = 256,
  parameter int W     = 20,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          pop,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  head_data,
  output logic [AW:0]   rd_ptr,
  output logic [AW:0]   wr_ptr,
  output logic [AW:0]   count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0] mem [DEPTH];
  logic do_wr, do_pop;

  assign count = wr_ptr - rd_ptr;
  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign do_wr  = wr_en && !full;
  assign do_pop = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_wr)  wr_ptr <= wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign rd_data   = mem[rd_addr];
  assign head_data = mem[rd_ptr[AW-1:0]];
endmodule

// File: rtl/tm_trig_fifo.sv
module tm_trig_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 24,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  logic [W-1:0] slots [DEPTH];
  logic [AW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = ((wp - rp) == (AW+1)'(DEPTH));
  assign dout  = slots[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) slots[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/trig_match.sv
module trig_match
  import tm_pkg::*;
#(
  parameter int BC_W       = 12,
  parameter int EVT_W      = 12,
  parameter int HIT_W      = 8,
  parameter int L1_DEPTH   = 256,
  parameter int TRIG_DEPTH = 4,
  parameter int DROP_W     = 8,
  localparam int PAY_W     = EVT_W + BC_W,
  localparam int OUT_W     = PAY_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_valid,
  input  logic [HIT_W-1:0]  hit_data,
  input  logic              trig_in,
  input  logic              bc_clr,
  input  logic [BC_W-1:0]   bc_preset,
  input  logic [BC_W-1:0]   win_offset,
  input  logic [BC_W-1:0]   win_width,
  input  logic [BC_W-1:0]   reject_lim,
  input  logic              bypass,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_data,
  output logic [DROP_W-1:0] drop_cnt
);
  localparam int AW     = $clog2(L1_DEPTH);
  localparam int L1_W   = BC_W + HIT_W;
  localparam int TQ_W   = EVT_W + BC_W;
  localparam int HCNT_W = $clog2(L1_DEPTH + 1);

  // bunch counter
  logic [BC_W-1:0] bc_now;
  tm_bunch_ctr #(.BC_W(BC_W)) u_bc (
    .clk(clk), .rst(rst), .clr(bc_clr), .preset(bc_preset), .bc(bc_now)
  );

  // level-1 hit store
  logic [AW-1:0] scan_addr;
  logic [L1_W-1:0] scan_ent, head_ent;
  logic [AW:0] l1_rp, l1_wp, l1_count;
  logic l1_full, l1_empty, l1_pop, hit_lost;

  tm_hit_buf #(.DEPTH(L1_DEPTH), .W(L1_W)) u_l1 (
    .clk(clk), .rst(rst),
    .wr_en(hit_valid), .wr_data({bc_now, hit_data}),
    .pop(l1_pop), .rd_addr(scan_addr), .rd_data(scan_ent),
    .head_data(head_ent), .rd_ptr(l1_rp), .wr_ptr(l1_wp),
    .count(l1_count), .full(l1_full), .empty(l1_empty)
  );
  assign hit_lost = hit_valid && l1_full;

  // trigger queue
  logic [EVT_W-1:0] evt_cnt;
  logic [TQ_W-1:0]  tq_head;
  logic tq_push, tq_pop, tq_full, tq_empty, tq_drop;

  assign tq_push = trig_in && !bypass && !tq_full;
  assign tq_drop = trig_in && !bypass && tq_full;

  tm_trig_fifo #(.DEPTH(TRIG_DEPTH), .W(TQ_W)) u_tq (
    .clk(clk), .rst(rst), .push(tq_push), .din({evt_cnt, bc_now}),
    .pop(tq_pop), .dout(tq_head), .full(tq_full), .empty(tq_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_cnt  <= '0;
      drop_cnt <= '0;
    end else begin
      if (tq_push) evt_cnt <= evt_cnt + 1'b1;
      if (tq_drop && (drop_cnt != '1)) drop_cnt <= drop_cnt + 1'b1;
    end
  end

  // window arithmetic, all modulo 2^BC_W
  logic [EVT_W-1:0] head_evt;
  logic [BC_W-1:0]  head_bc, head_ws, since_ws, head_age;
  logic             win_closed, aged;
  assign {head_evt, head_bc} = tq_head;
  assign head_ws    = head_bc - win_offset;
  assign since_ws   = bc_now - head_ws;
  assign win_closed = (since_ws >= win_width);
  assign head_age   = bc_now - head_ent[L1_W-1:HIT_W];
  assign aged       = (head_age > reject_lim);

  // matching state machine
  match_state_t       st, st_n;
  logic [EVT_W-1:0]   cur_evt;
  logic [BC_W-1:0]    cur_bc, cur_ws, scan_off;
  logic [AW:0]        sp, sp_n, sp_end;
  logic [HCNT_W-1:0]  hcnt, hcnt_n;
  logic               ovf_flag, can_load, load, trl_load;
  logic               start, byp_go, rej_go, in_win;
  logic [OUT_W-1:0]   nxt;

  assign can_load  = !out_valid || out_ready;
  assign start     = (st == ST_IDLE) && !bypass && !tq_empty && win_closed;
  assign byp_go    = (st == ST_IDLE) && bypass && !l1_empty && can_load;
  assign rej_go    = (st == ST_IDLE) && !bypass && !start && !l1_empty && aged;
  assign l1_pop    = byp_go || rej_go;
  assign tq_pop    = start;
  assign scan_addr = sp[AW-1:0];
  assign scan_off  = scan_ent[L1_W-1:HIT_W] - cur_ws;
  assign in_win    = (scan_off < win_width);

  always_comb begin
    st_n     = st;
    sp_n     = sp;
    hcnt_n   = hcnt;
    load     = 1'b0;
    trl_load = 1'b0;
    nxt      = '0;
    unique case (st)
      ST_IDLE: begin
        if (byp_go) begin
          load = 1'b1;
          nxt  = {K_HIT, PAY_W'(head_ent)};
        end else if (start) begin
          st_n = ST_HDR;
        end
      end
      ST_HDR: begin
        if (can_load) begin
          load   = 1'b1;
          nxt    = {K_HDR, cur_evt, cur_bc};
          hcnt_n = '0;
          st_n   = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (sp == sp_end) begin
          st_n = ST_TRL;
        end else if (in_win) begin
          if (can_load) begin
            load   = 1'b1;
            nxt    = {K_HIT, PAY_W'(scan_ent)};
            sp_n   = sp + 1'b1;
            hcnt_n = hcnt + 1'b1;
          end
        end else begin
          sp_n = sp + 1'b1;
        end
      end
      ST_TRL: begin
        if (can_load) begin
          load     = 1'b1;
          trl_load = 1'b1;
          nxt      = {K_TRL, PAY_W'({ovf_flag, hcnt})};
          st_n     = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      sp       <= '0;
      sp_end   <= '0;
      hcnt     <= '0;
      cur_evt  <= '0;
      cur_bc   <= '0;
      cur_ws   <= '0;
      ovf_flag <= 1'b0;
    end else begin
      st       <= st_n;
      hcnt     <= hcnt_n;
      ovf_flag <= hit_lost || (ovf_flag && !trl_load);
      if (start) begin
        cur_evt <= head_evt;
        cur_bc  <= head_bc;
        cur_ws  <= head_ws;
        sp      <= l1_rp;
        sp_end  <= l1_wp;
      end else begin
        sp <= sp_n;
      end
    end
  end

  // registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= nxt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/trig_match_chk.sv
module trig_match_chk #(
  parameter int BC_W     = 12,
  parameter int OUT_W    = 26,
  parameter int DROP_W   = 8,
  parameter int L1_DEPTH = 256,
  localparam int AW      = $clog2(L1_DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              out_valid,
  input logic              out_ready,
  input logic [OUT_W-1:0]  out_data,
  input logic [DROP_W-1:0] drop_cnt,
  input logic [BC_W-1:0]   bc_now,
  input logic              bc_clr,
  input logic [BC_W-1:0]   bc_preset,
  input logic [AW:0]       l1_count
);
  // R1: counter loads preset on clear
  p_bc_load_r1: assert property (@(posedge clk) disable iff (rst)
    bc_clr |=> (bc_now == $past(bc_preset)));

  // R1: counter advances by one otherwise
  p_bc_step_r1: assert property (@(posedge clk) disable iff (rst)
    !bc_clr |=> (bc_now == BC_W'($past(bc_now) + 1'b1)));

  // R6: the store never holds more than its depth
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    l1_count <= (AW+1)'(L1_DEPTH));

  // R7: drop counter only steps by one
  p_drop_step_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(drop_cnt) |-> (drop_cnt == DROP_W'($past(drop_cnt) + 1'b1)));

  // R9: stalled word is held
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10: reset clears valid and drop count
  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!out_valid && drop_cnt == '0));
endmodule

bind trig_match trig_match_chk #(
  .BC_W(BC_W), .OUT_W(OUT_W), .DROP_W(DROP_W), .L1_DEPTH(L1_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .drop_cnt(drop_cnt), .bc_now(bc_now),
  .bc_clr(bc_clr), .bc_preset(bc_preset), .l1_count(l1_count)
);

// File: tb/trig_match_tb.sv
module trig_match_tb;
  localparam int BC_W   = 12;
  localparam int EVT_W  = 12;
  localparam int HIT_W  = 8;
  localparam int DEPTH  = 16;
  localparam int TQD    = 4;
  localparam int DROP_W = 8;
  localparam int HCNT_W = $clog2(DEPTH + 1);
  localparam int PAY_W  = EVT_W + BC_W;
  localparam int OUT_W  = PAY_W + 2;
  localparam int M      = 1 << BC_W;
  localparam int LIM_MAX = M - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hit_valid = 1'b0;
  logic [HIT_W-1:0] hit_data = '0;
  logic trig_in = 1'b0, bc_clr = 1'b0, bypass = 1'b0, out_ready = 1'b1;
  logic [BC_W-1:0] bc_preset = '0, win_offset = 12'd8, win_width = 12'd4;
  logic [BC_W-1:0] reject_lim = 12'(LIM_MAX);
  logic out_valid;
  logic [OUT_W-1:0] out_data;
  logic [DROP_W-1:0] drop_cnt;

  always #5 clk = ~clk;

  trig_match #(
    .BC_W(BC_W), .EVT_W(EVT_W), .HIT_W(HIT_W), .L1_DEPTH(DEPTH),
    .TRIG_DEPTH(TQD), .DROP_W(DROP_W)
  ) u_dut (
    .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_data(hit_data),
    .trig_in(trig_in), .bc_clr(bc_clr), .bc_preset(bc_preset),
    .win_offset(win_offset), .win_width(win_width), .reject_lim(reject_lim),
    .bypass(bypass), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .drop_cnt(drop_cnt)
  );

  int n_run = 0, n_fail = 0;
  int hit_tag[$], hit_dat[$], trg_bc[$], trg_evt[$];
  logic [OUT_W-1:0] got[$], expq[$];
  int bc_m = 0, evt_m = 0, trig_cap = 1000, first_err = 0;

  // behavioural reference: tags inputs, collects outputs
  always @(negedge clk) begin
    if (out_valid && out_ready) got.push_back(out_data);
    if (!rst) begin
      if (hit_valid) begin
        if (hit_tag.size() < DEPTH) begin
          hit_tag.push_back(bc_m);
          hit_dat.push_back(int'(hit_data));
        end else if (trg_bc.size() == 0) first_err = 1;
      end
      if (trig_in && !bypass && trg_bc.size() < trig_cap) begin
        trg_bc.push_back(bc_m);
        trg_evt.push_back(evt_m);
        evt_m++;
      end
    end
    if (rst) begin
      bc_m = 0;
      evt_m = 0;
    end else if (bc_clr) bc_m = int'(bc_preset);
    else bc_m = (bc_m + 1) % M;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic hit(input int d);
    hit_valid = 1'b1;
    hit_data = HIT_W'(d);
    cyc(1);
    hit_valid = 1'b0;
  endtask

  task automatic trig();
    trig_in = 1'b1;
    cyc(1);
    trig_in = 1'b0;
  endtask

  task automatic new_phase();
    rst = 1'b1;
    cyc(3);
    hit_tag.delete(); hit_dat.delete(); trg_bc.delete(); trg_evt.delete();
    got.delete(); expq.delete();
    first_err = 0;
    trig_cap = 1000;
    rst = 1'b0;
    cyc(1);
  endtask

  function automatic logic [OUT_W-1:0] w_hit(input int tag, input int d);
    return OUT_W'((longint'(tag) << HIT_W) | longint'(d));
  endfunction

  // expected event stream from recorded hits and triggers
  task automatic build_events();
    for (int i = 0; i < trg_bc.size(); i++) begin
      int ws, cnt;
      cnt = 0;
      ws = (trg_bc[i] - int'(win_offset) + M) % M;
      expq.push_back(OUT_W'((longint'(2) << PAY_W) | (longint'(trg_evt[i]) << BC_W) | trg_bc[i]));
      for (int h = 0; h < hit_tag.size(); h++) begin
        int rel, age;
        rel = (hit_tag[h] - ws + M) % M;
        age = (trg_bc[i] - hit_tag[h] + M) % M;
        if (rel < int'(win_width) && (int'(reject_lim) == LIM_MAX || age <= int'(reject_lim))) begin
          expq.push_back(w_hit(hit_tag[h], hit_dat[h]));
          cnt++;
        end
      end
      expq.push_back(OUT_W'((longint'(3) << PAY_W) |
                     (longint'((i == 0) ? first_err : 0) << HCNT_W) | cnt));
    end
  endtask

  task automatic compare(input string req);
    chk(got.size() == expq.size(), {req, " word count"}, got.size(), expq.size());
    for (int i = 0; i < expq.size() && i < got.size(); i++)
      chk(got[i] === expq[i], req, got[i], expq[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cyc(4);
    // R10 reset state
    chk(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
    chk(drop_cnt == '0, "R10 drop_cnt", drop_cnt, 0);

    // R1 R2 R3 R11: preset load, single window
    new_phase();
    bc_preset = 12'd100;
    bc_clr = 1'b1; cyc(1); bc_clr = 1'b0;
    for (int i = 0; i < 12; i++) hit(16 + i);
    trig();
    cyc(20);
    trig();
    cyc(40);
    build_events();
    compare("R1 R2 R3 R11 basic window");

    // R4: overlapping windows that reach past the trigger
    new_phase();
    win_offset = 12'd3; win_width = 12'd6;
    for (int i = 0; i < 12; i++) begin
      trig_in = (i == 5 || i == 7);
      hit(40 + i);
    end
    trig_in = 1'b0;
    cyc(60);
    build_events();
    compare("R4 overlap");

    // R5: aged hits removed; wide limit keeps them
    for (int pass = 0; pass < 2; pass++) begin
      new_phase();
      win_offset = 12'd20; win_width = 12'd5;
      reject_lim = (pass == 0) ? 12'd3 : 12'(LIM_MAX);
      cyc(2); hit(7); hit(8);
      cyc(16);
      trig();
      cyc(30);
      build_events();
      compare((pass == 0) ? "R5 reject" : "R5 kept");
    end
    reject_lim = 12'(LIM_MAX);

    // R6: store overflow flags next trailer only
    new_phase();
    win_offset = 12'd25; win_width = 12'd26;
    for (int i = 0; i < DEPTH + 3; i++) hit(100 + i);
    trig();
    cyc(8);
    trig();
    cyc(80);
    build_events();
    compare("R6 overflow");

    // R7: full trigger queue under back-pressure
    new_phase();
    win_offset = 12'd8; win_width = 12'd4;
    out_ready = 1'b0;
    trig_cap = TQD + 1;
    trig_in = 1'b1; cyc(7); trig_in = 1'b0;
    cyc(2);
    chk(drop_cnt == 8'd2, "R7 drop_cnt", drop_cnt, 2);
    chk(out_valid == 1'b1, "R9 stalled valid", out_valid, 1);
    out_ready = 1'b1;
    cyc(40);
    build_events();
    compare("R7 accepted events");

    // R8 R9: bypass with ready toggling, triggers ignored
    new_phase();
    bypass = 1'b1;
    for (int i = 0; i < 5; i++) begin
      trig_in = (i == 2);
      out_ready = (i % 2 == 0);
      hit(200 + i);
    end
    trig_in = 1'b0;
    cyc(3);
    out_ready = 1'b1;
    cyc(20);
    chk(drop_cnt == '0, "R8 drop_cnt", drop_cnt, 0);
    for (int h = 0; h < hit_tag.size(); h++) expq.push_back(w_hit(hit_tag[h], hit_dat[h]));
    compare("R8 bypass stream");
    bypass = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule